// File: doc/BRIEF.md
# Single-Wire Configuration Register Slave

This block is a slave on a single open-drain wire. Through it a bus master reads and writes two 9-bit configuration words: a divider word and a mode word. The block runs from a fast sampling clock and observes the wire through a synchronizer. It measures every low period by counting sampling-clock ticks. When it answers, it asserts an active-low pull-down enable, which is used for the presence response and for read-zero bits. Both words are always visible as parallel outputs. A one-cycle strobe marks each completed write.

A transaction has four parts. It opens with a long low pulse from the master, and the slave answers with a presence pulse. Next comes an 8-bit command and then exactly nine data bits. Both the command and the data travel least significant bit first. There is no addressing layer. After the ninth data bit the slave ignores the wire until the master sends another long low pulse. Every time interval is a parameter in microseconds, scaled by the number of sampling ticks in one microsecond.

Top module: `owc_cfg_slave`

## Requirements
- R1: After reset the divider word reads 0x000 and the mode word reads 0x034. The pull-down is released (pull_n_o = 1) and the strobe is low.
- R2: A low period longer than RESET_US, followed by a release, makes the slave pull the wire low. The pull starts after a wait of PRES_WAIT_US and lasts for PRES_US, then the slave releases the wire.
- R3: A low period shorter than RESET_US does not cause a presence pulse, and the slave does not pull the wire.
- R4: Each bit slot starts on a falling edge of the wire. The slave samples the wire SAMPLE_US later: a high level is a 1 and a low level is a 0. Command code 0x01, sent LSB first, followed by nine bits sent LSB first, loads those nine bits into the divider word.
- R5: Command code 0x02 followed by nine bits loads those bits into the mode word. The divider word does not change.
- R6: Command code 0xA1 returns the divider word in the nine following slots, LSB first. For a 0 bit the slave holds the wire low for HOLD_US after the falling edge of the slot. For a 1 bit the slave leaves the wire alone.
- R7: Command code 0xA2 returns the mode word in the same way as R6.
- R8: A write changes its word only when the ninth data bit is sampled. At that point wr_strobe_o goes high for exactly one cycle. A read transaction produces no strobe.
- R9: Any other command code makes the slave ignore the wire until the next long low pulse. It sends no pulls and changes no word.
- R10: After the ninth data bit, further slots have no effect. They produce no pull, no strobe and no change to either word.
- R11: A long low pulse in the middle of a transaction aborts it, discards any partial write and brings a new presence pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_i | input | 1 | Observed level of the wire |
| pull_n_o | output | 1 | Active-low enable for the external pull-down |
| div_word_o | output | DATA_W | Divider word |
| mode_word_o | output | DATA_W | Mode word |
| wr_strobe_o | output | 1 | One-cycle pulse when a write completes |

## Verification
Some properties are checked by assertions on every cycle:
- The strobe is always a single-cycle pulse.
- Neither word changes unless the strobe is high.
- One strobe never changes both words.
- The pull-down is never held longer than a presence pulse.

Other behaviour can only be shown by the bench scenarios:
- LSB-first decoding of commands and data.
- The timing of presence pulses and read-zero bits.
- Rejection of short pulses and unknown codes.
- The wire being ignored once a transaction is finished.
- Aborting a transaction with a long low pulse in the middle.

// File: rtl/owc_pkg.sv
package owc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWAIT,
    ST_PDRV,
    ST_CMD,
    ST_WR,
    ST_RD,
    ST_DONE
  } owc_state_e;

  localparam logic [7:0] OP_WR_DIV  = 8'h01;
  localparam logic [7:0] OP_RD_DIV  = 8'hA1;
  localparam logic [7:0] OP_WR_MODE = 8'h02;
  localparam logic [7:0] OP_RD_MODE = 8'hA2;
endpackage

// File: rtl/owc_line_front.sv
module owc_line_front #(
  parameter int SYNC_STAGES = 2,
  parameter int RESET_TICKS = 3840
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_s_o,
  output logic fall_o,
  output logic bus_rst_o
);
  localparam int LOW_W = $clog2(RESET_TICKS + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [LOW_W-1:0]       low_q, low_n;
  logic                   line_s;

  assign line_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (line_s)                          low_n = '0;
    else if (low_q != LOW_W'(RESET_TICKS)) low_n = low_q + 1'b1;
    else                                 low_n = low_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
      low_q  <= '0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      prev_q <= line_s;
      low_q  <= low_n;
    end
  end

  assign line_s_o  = line_s;
  assign fall_o    = prev_q & ~line_s;
  assign bus_rst_o = ~prev_q & line_s & (low_q == LOW_W'(RESET_TICKS));
endmodule

// File: rtl/owc_slot_timer.sv
module owc_slot_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         run_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q, cnt_n;

  always_comb begin
    if (clear_i)    cnt_n = '0;
    else if (run_i) cnt_n = cnt_q + 1'b1;
    else            cnt_n = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/owc_shifter.sv
module owc_shifter #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] sh_q, sh_n;

  always_comb begin
    if (load_i)       sh_n = load_val_i;
    else if (shift_i) sh_n = {bit_i, sh_q[W-1:1]};
    else              sh_n = sh_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  assign q_o = sh_q;
endmodule

// File: rtl/owc_cfg_slave.sv
module owc_cfg_slave
  import owc_pkg::*;
#(
  parameter int TICKS_PER_US = 8,
  parameter int RESET_US     = 480,
  parameter int PRES_WAIT_US = 30,
  parameter int PRES_US      = 120,
  parameter int SAMPLE_US    = 30,
  parameter int HOLD_US      = 30,
  parameter int SYNC_STAGES  = 2,
  parameter int DATA_W       = 9,
  parameter int CMD_W        = 8,
  parameter logic [DATA_W-1:0] DIV_INIT  = '0,
  parameter logic [DATA_W-1:0] MODE_INIT = 9'h034
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic              pull_n_o,
  output logic [DATA_W-1:0] div_word_o,
  output logic [DATA_W-1:0] mode_word_o,
  output logic              wr_strobe_o
);
  localparam int RESET_T = TICKS_PER_US * RESET_US;
  localparam int WAIT_T  = TICKS_PER_US * PRES_WAIT_US;
  localparam int PRES_T  = TICKS_PER_US * PRES_US;
  localparam int SAMP_T  = TICKS_PER_US * SAMPLE_US;
  localparam int HOLD_T  = TICKS_PER_US * HOLD_US;
  localparam int MAX_AB  = (WAIT_T > PRES_T) ? WAIT_T : PRES_T;
  localparam int MAX_CD  = (SAMP_T > HOLD_T) ? SAMP_T : HOLD_T;
  localparam int MAX_T   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TW      = $clog2(MAX_T + 1);
  localparam int BW      = $clog2(DATA_W + 1);

  owc_state_e        state_q, state_n;
  logic [BW-1:0]     bit_q, bit_n;
  logic              slot_q, slot_n;
  logic              tgt_q, tgt_n;
  logic [DATA_W-1:0] div_q, div_n, mode_q, mode_n;
  logic              stb_q, stb_n;

  logic              line_s, fall, bus_rst;
  logic              t_clr, t_run;
  logic [TW-1:0]     t_cnt;
  logic              sh_load, sh_shift;
  logic [DATA_W-1:0] sh_val, sh_q, shift_in;
  logic [CMD_W-1:0]  cmd_in;

  owc_line_front #(.SYNC_STAGES(SYNC_STAGES), .RESET_TICKS(RESET_T)) front_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .line_s_o(line_s), .fall_o(fall), .bus_rst_o(bus_rst)
  );

  owc_slot_timer #(.W(TW)) timer_i (
    .clk(clk), .rst_n(rst_n), .clear_i(t_clr), .run_i(t_run), .count_o(t_cnt)
  );

  owc_shifter #(.W(DATA_W)) shift_i (
    .clk(clk), .rst_n(rst_n), .load_i(sh_load), .load_val_i(sh_val),
    .shift_i(sh_shift), .bit_i(line_s), .q_o(sh_q)
  );

  assign shift_in = {line_s, sh_q[DATA_W-1:1]};
  assign cmd_in   = shift_in[DATA_W-1 -: CMD_W];

  always_comb begin
    state_n  = state_q;
    bit_n    = bit_q;
    slot_n   = slot_q;
    tgt_n    = tgt_q;
    div_n    = div_q;
    mode_n   = mode_q;
    stb_n    = 1'b0;
    t_clr    = 1'b0;
    t_run    = 1'b0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    sh_val   = div_q;
    if (bus_rst) begin
      state_n = ST_PWAIT;
      t_clr   = 1'b1;
      slot_n  = 1'b0;
      bit_n   = '0;
    end else begin
      case (state_q)
        ST_PWAIT: begin
          t_run = 1'b1;
          if (t_cnt == TW'(WAIT_T - 1)) begin
            state_n = ST_PDRV;
            t_clr   = 1'b1;
          end
        end
        ST_PDRV: begin
          t_run = 1'b1;
          if (t_cnt == TW'(PRES_T - 1)) begin
            state_n = ST_CMD;
            t_clr   = 1'b1;
            bit_n   = '0;
            slot_n  = 1'b0;
          end
        end
        ST_CMD, ST_WR: begin
          if (!slot_q) begin
            if (fall) begin
              slot_n = 1'b1;
              t_clr  = 1'b1;
            end
          end else begin
            t_run = 1'b1;
            if (t_cnt == TW'(SAMP_T - 1)) begin
              slot_n   = 1'b0;
              sh_shift = 1'b1;
              bit_n    = bit_q + 1'b1;
              if (state_q == ST_CMD && bit_q == BW'(CMD_W - 1)) begin
                bit_n = '0;
                if (cmd_in == CMD_W'(OP_WR_DIV)) begin
                  state_n = ST_WR;
                  tgt_n   = 1'b0;
                end else if (cmd_in == CMD_W'(OP_WR_MODE)) begin
                  state_n = ST_WR;
                  tgt_n   = 1'b1;
                end else if (cmd_in == CMD_W'(OP_RD_DIV)) begin
                  state_n = ST_RD;
                  sh_load = 1'b1;
                  sh_val  = div_q;
                end else if (cmd_in == CMD_W'(OP_RD_MODE)) begin
                  state_n = ST_RD;
                  sh_load = 1'b1;
                  sh_val  = mode_q;
                end else begin
                  state_n = ST_DONE;
                end
              end else if (state_q == ST_WR && bit_q == BW'(DATA_W - 1)) begin
                state_n = ST_DONE;
                stb_n   = 1'b1;
                if (tgt_q) mode_n = shift_in;
                else       div_n  = shift_in;
              end
            end
          end
        end
        ST_RD: begin
          if (!slot_q) begin
            if (fall) begin
              slot_n = 1'b1;
              t_clr  = 1'b1;
            end
          end else begin
            t_run = 1'b1;
            if (t_cnt == TW'(HOLD_T - 1)) begin
              slot_n   = 1'b0;
              sh_shift = 1'b1;
              bit_n    = bit_q + 1'b1;
              if (bit_q == BW'(DATA_W - 1)) state_n = ST_DONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      slot_q  <= 1'b0;
      tgt_q   <= 1'b0;
      div_q   <= DIV_INIT;
      mode_q  <= MODE_INIT;
      stb_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      bit_q   <= bit_n;
      slot_q  <= slot_n;
      tgt_q   <= tgt_n;
      div_q   <= div_n;
      mode_q  <= mode_n;
      stb_q   <= stb_n;
    end
  end

  assign pull_n_o    = ~((state_q == ST_PDRV) | ((state_q == ST_RD) & slot_q & ~sh_q[0]));
  assign div_word_o  = div_q;
  assign mode_word_o = mode_q;
  assign wr_strobe_o = stb_q;
endmodule

// File: rtl/owc_cfg_slave_chk.sv
module owc_cfg_slave_chk #(
  parameter int TICKS_PER_US = 8,
  parameter int PRES_US      = 120,
  parameter int DATA_W       = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pull_n_o,
  input logic [DATA_W-1:0] div_word_o,
  input logic [DATA_W-1:0] mode_word_o,
  input logic              wr_strobe_o
);
  localparam int LIM = TICKS_PER_US * PRES_US;
  localparam int RW  = $clog2(LIM + 2);

  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          run_q <= '0;
    else if (pull_n_o)                   run_q <= '0;
    else if (run_q != RW'(LIM + 1))      run_q <= run_q + 1'b1;
  end

  // R8
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |=> !wr_strobe_o);

  // R8
  div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_o |-> $stable(div_word_o));

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_strobe_o |-> $stable(mode_word_o));

  // R5
  one_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |-> ($stable(div_word_o) || $stable(mode_word_o)));

  // R2
  pull_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RW'(LIM));
endmodule

bind owc_cfg_slave owc_cfg_slave_chk #(
  .TICKS_PER_US(TICKS_PER_US),
  .PRES_US(PRES_US),
  .DATA_W(DATA_W)
) chk_i (
  .clk(clk),
  .rst_n(rst_n),
  .pull_n_o(pull_n_o),
  .div_word_o(div_word_o),
  .mode_word_o(mode_word_o),
  .wr_strobe_o(wr_strobe_o)
);

// File: tb/owc_cfg_slave_tb_top.sv
`timescale 1ns/1ps
module owc_cfg_slave_tb_top;
  localparam int DW = 9;

  logic          clk;
  logic          rst_n;
  logic          line_m;
  logic          pull_n;
  logic [DW-1:0] div_w, mode_w;
  logic          stb;
  wire           line_w = line_m & pull_n;

  int compared   = 0;
  int mismatched = 0;
  int pull_cyc   = 0;
  int stb_cnt    = 0;
  int exp_stb    = 0;
  bit busy       = 1'b1;
  bit finished   = 1'b0;
  logic [DW-1:0] m_div  = 9'h000;
  logic [DW-1:0] m_mode = 9'h034;

  owc_cfg_slave #(.TICKS_PER_US(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .line_i(line_w), .pull_n_o(pull_n),
    .div_word_o(div_w), .mode_word_o(mode_w), .wr_strobe_o(stb)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // reference comparison of the register outputs on every idle clock (R8, R10)
  always @(negedge clk) begin
    if (rst_n) begin
      if (!pull_n) pull_cyc++;
      if (stb) stb_cnt++;
      if (!busy) begin
        chk(div_w == m_div, "R8 div word", div_w, m_div);
        chk(mode_w == m_mode, "R8 mode word", mode_w, m_mode);
        chk(stb == 1'b0, "R8 idle strobe", stb, 0);
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_reset(input string req);
    line_m = 1'b0;
    wait_cyc(500);
    line_m = 1'b1;
    wait_cyc(70);
    chk(line_w == 1'b0, {req, " presence low"}, line_w, 0);
    wait_cyc(180);
    chk(line_w == 1'b1, {req, " presence released"}, line_w, 1);
  endtask

  task automatic wr_bit(input bit b);
    line_m = 1'b0;
    wait_cyc(b ? 5 : 60);
    line_m = 1'b1;
    wait_cyc(b ? 75 : 20);
  endtask

  task automatic rd_bit(output bit b);
    line_m = 1'b0;
    wait_cyc(3);
    line_m = 1'b1;
    wait_cyc(12);
    b = line_w;
    wait_cyc(65);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) wr_bit(v[i]);
  endtask

  task automatic write_word(input logic [7:0] op, input logic [DW-1:0] v, input string req);
    busy = 1'b1;
    bus_reset(req);
    send_byte(op);
    for (int i = 0; i < DW; i++) wr_bit(v[i]);
    wait_cyc(20);
    if (op == 8'h01) begin m_div = v; exp_stb++; end
    if (op == 8'h02) begin m_mode = v; exp_stb++; end
    busy = 1'b0;
    wait_cyc(5);
  endtask

  task automatic read_word(input logic [7:0] op, output logic [DW-1:0] v, input string req);
    bit b;
    busy = 1'b1;
    bus_reset(req);
    send_byte(op);
    for (int i = 0; i < DW; i++) begin
      rd_bit(b);
      v[i] = b;
    end
    busy = 1'b0;
    wait_cyc(5);
  endtask

  logic [DW-1:0] rv;
  int            p0;
  bit            bb;

  initial begin
    line_m = 1'b1;
    rst_n  = 1'b0;
    wait_cyc(5);
    // R1 reset state
    chk(pull_n == 1'b1, "R1 pull released", pull_n, 1);
    chk(div_w == 9'h000, "R1 div reset", div_w, 0);
    chk(mode_w == 9'h034, "R1 mode reset", mode_w, 9'h034);
    chk(stb == 1'b0, "R1 strobe reset", stb, 0);
    rst_n = 1'b1;
    busy  = 1'b0;
    wait_cyc(10);

    // R3 short low pulse: no presence, no pulls in following slots
    p0 = pull_cyc;
    line_m = 1'b0; wait_cyc(100); line_m = 1'b1; wait_cyc(200);
    rd_bit(bb);
    chk(bb == 1'b1, "R3 slot after short pulse", bb, 1);
    chk(pull_cyc == p0, "R3 no pull", pull_cyc - p0, 0);

    // R6/R7 read defaults
    read_word(8'hA1, rv, "R6");
    chk(rv == m_div, "R6 read div default", rv, m_div);
    read_word(8'hA2, rv, "R7");
    chk(rv == m_mode, "R7 read mode default", rv, m_mode);

    // R4 write divider, R5 write mode
    write_word(8'h01, 9'h1A5, "R4");
    read_word(8'hA1, rv, "R4");
    chk(rv == 9'h1A5, "R4 div written", rv, 9'h1A5);
    write_word(8'h02, 9'h0CB, "R5");
    read_word(8'hA2, rv, "R5");
    chk(rv == 9'h0CB, "R5 mode written", rv, 9'h0CB);
    read_word(8'hA1, rv, "R5");
    chk(rv == 9'h1A5, "R5 div untouched", rv, 9'h1A5);

    // R4/R6 boundary values
    write_word(8'h01, 9'h1FF, "R4");
    read_word(8'hA1, rv, "R6");
    chk(rv == 9'h1FF, "R6 read all ones", rv, 9'h1FF);
    write_word(8'h01, 9'h100, "R4");
    read_word(8'hA1, rv, "R6");
    chk(rv == 9'h100, "R6 read msb only", rv, 9'h100);

    // R8 strobe count: one per write, none for reads
    chk(stb_cnt == exp_stb, "R8 strobe count", stb_cnt, exp_stb);

    // R9 unknown codes
    p0 = pull_cyc;
    write_word(8'h55, 9'h000, "R9");
    read_word(8'hA0, rv, "R9");
    chk(rv == 9'h1FF, "R9 unknown read code ignored", rv, 9'h1FF);
    chk(pull_cyc - p0 == 2 * 120, "R9 only presence pulls", pull_cyc - p0, 240);
    chk(stb_cnt == exp_stb, "R9 no strobe", stb_cnt, exp_stb);

    // R10 extra slots after a completed write and read
    busy = 1'b1;
    bus_reset("R10");
    send_byte(8'h02);
    for (int i = 0; i < DW; i++) wr_bit(1'b1);
    m_mode = 9'h1FF; exp_stb++;
    p0 = pull_cyc;
    for (int i = 0; i < 4; i++) wr_bit(1'b0);
    wait_cyc(10);
    busy = 1'b0;
    wait_cyc(5);
    chk(mode_w == 9'h1FF, "R10 extra write slots ignored", mode_w, 9'h1FF);
    chk(stb_cnt == exp_stb, "R10 no extra strobe", stb_cnt, exp_stb);
    busy = 1'b1;
    bus_reset("R10");
    send_byte(8'hA1);
    for (int i = 0; i < DW; i++) rd_bit(bb);
    p0 = pull_cyc;
    for (int i = 0; i < 3; i++) begin
      rd_bit(bb);
      chk(bb == 1'b1, "R10 extra read slot", bb, 1);
    end
    chk(pull_cyc == p0, "R10 no pull after read", pull_cyc - p0, 0);
    busy = 1'b0;
    wait_cyc(5);

    // R11 abort by reset mid-transaction
    busy = 1'b1;
    bus_reset("R11");
    send_byte(8'h01);
    for (int i = 0; i < 4; i++) wr_bit(1'b0);
    bus_reset("R11");
    busy = 1'b0;
    wait_cyc(5);
    chk(div_w == 9'h100, "R11 partial write discarded", div_w, 9'h100);
    read_word(8'hA1, rv, "R11");
    chk(rv == 9'h100, "R11 transaction after abort", rv, 9'h100);
    chk(stb_cnt == exp_stb, "R11 strobe count", stb_cnt, exp_stb);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule